// File: doc/BRIEF.md
# Fly-by Four-Channel DMA Controller

This block moves blocks of words directly between an I/O device and memory without holding any data itself. The processor gives each of four channels a start address, a word count and a direction through a small register write port. An armed channel whose device raises its request line makes the controller ask the processor for the bus. Once the processor grants it, the controller acknowledges that device. It then runs strobe cycles on the shared address bus, one word at a time, until the count runs out.

The data lines run from the device straight to memory. The controller drives only the address and the strobes. For memory to device it reads memory and writes the port in the same cycle. For device to memory it reads the port and writes memory. When the last word is done the controller drops its bus request and pulses that channel's interrupt line for one cycle. The channel then stays idle until software writes a new count.

Top module: `flyby_dma`

## Requirements
- R1: After reset, hold_req, every dack bit, every irq bit, addr and all four strobes are low, and no channel is armed.
- R2: Writing with cfg_sel=0 loads the channel's start address and cfg_sel=2 loads its direction from cfg_wdata[0] (0 = memory to device, 1 = device to memory). cfg_sel=1 loads its word count, and a nonzero count arms the channel. A write aimed at the channel currently in service is ignored.
- R3: One cycle after an armed channel sees its dreq bit high while the controller is idle, hold_req goes high. A dreq on an unarmed channel has no effect.
- R4: While hold_ack stays low, every dack bit stays low. One cycle after hold_ack is seen, the served channel's dack bit rises and stays high for the whole transfer.
- R5: When several armed channels request at once, the lowest-numbered one is served first, and at most one dack bit is ever high.
- R6: Each memory-to-device word takes two cycles with addr steady: first mem_rd alone, then mem_rd together with io_wr.
- R7: Each device-to-memory word takes two cycles with addr steady: first io_rd alone, then io_rd together with mem_wr.
- R8: Successive words use the start address plus 0, 1, 2 and so on, wrapping modulo 2^16. Exactly count words are moved, and a channel keeps going after its dreq drops.
- R9: In the cycle after the last word, hold_req is low and irq has the served channel's bit high for exactly one cycle. After that the channel is disarmed.
- R10: mem_rd and mem_wr are never high together, and io_rd and io_wr are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_ch | input | 2 | Channel addressed by the write |
| cfg_sel | input | 2 | 0 address, 1 count (arms), 2 direction |
| cfg_wdata | input | 16 | Write data |
| dreq | input | 4 | Per-channel service request from devices |
| dack | output | 4 | Per-channel acknowledge to devices |
| hold_req | output | 1 | Bus request to the processor |
| hold_ack | input | 1 | Bus grant from the processor |
| addr | output | 16 | Memory address of the current word |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| io_rd | output | 1 | Device read strobe |
| io_wr | output | 1 | Device write strobe |
| irq | output | 4 | Per-channel one-cycle completion interrupt |

## Verification
A wrong served-channel register shows up at once as the wrong dack bit or the wrong address sequence, one cycle after the grant. A miscounted word counter shows at the end of the transfer. There, the interrupt arrives one word pair early or late, and a channel that should be disarmed asks for the bus again at its next request. A bad step of the address pointer appears at the second word of any transfer. A bad wrap appears at the 16'hFFFF to 16'h0000 crossing.

// File: rtl/flyby_dma.sv
module flyby_dma #(
  parameter int NCH = 4,
  parameter int AW  = 16,
  parameter int CW  = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cfg_we,
  input  logic [$clog2(NCH)-1:0] cfg_ch,
  input  logic [1:0]             cfg_sel,
  input  logic [AW-1:0]          cfg_wdata,
  input  logic [NCH-1:0]         dreq,
  output logic [NCH-1:0]         dack,
  output logic                   hold_req,
  input  logic                   hold_ack,
  output logic [AW-1:0]          addr,
  output logic                   mem_rd,
  output logic                   mem_wr,
  output logic                   io_rd,
  output logic                   io_wr,
  output logic [NCH-1:0]         irq
);
  localparam int CHW = $clog2(NCH);

  typedef enum logic [2:0] {S_IDLE, S_HOLD, S_RD, S_WR, S_FIN} state_t;
  state_t state;

  logic [AW-1:0]  addr_q [NCH];
  logic [CW-1:0]  cnt_q  [NCH];
  logic [NCH-1:0] dir_q;
  logic [CHW-1:0] cur, pick;
  logic           found, busy, xfer, last;

  always_comb begin
    pick  = '0;
    found = 1'b0;
    for (int i = NCH - 1; i >= 0; i--)
      if (cnt_q[i] != '0 && dreq[i]) begin
        pick  = i[CHW-1:0];
        found = 1'b1;
      end
  end

  assign busy     = state != S_IDLE;
  assign xfer     = state == S_RD || state == S_WR;
  assign last     = cnt_q[cur] == {{(CW-1){1'b0}}, 1'b1};
  assign hold_req = state == S_HOLD || xfer;
  assign dack     = xfer ? (NCH'(1) << cur) : '0;
  assign irq      = state == S_FIN ? (NCH'(1) << cur) : '0;
  assign addr     = xfer ? addr_q[cur] : '0;
  assign mem_rd   = xfer && !dir_q[cur];
  assign io_rd    = xfer && dir_q[cur];
  assign io_wr    = state == S_WR && !dir_q[cur];
  assign mem_wr   = state == S_WR && dir_q[cur];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE;
      cur   <= '0;
      dir_q <= '0;
      for (int i = 0; i < NCH; i++) begin
        addr_q[i] <= '0;
        cnt_q[i]  <= '0;
      end
    end else begin
      if (cfg_we && !(busy && cfg_ch == cur))
        case (cfg_sel)
          2'd0: addr_q[cfg_ch] <= cfg_wdata;
          2'd1: cnt_q[cfg_ch]  <= CW'(cfg_wdata);
          2'd2: dir_q[cfg_ch]  <= cfg_wdata[0];
          default: ;
        endcase
      case (state)
        S_IDLE: if (found) begin
          cur   <= pick;
          state <= S_HOLD;
        end
        S_HOLD: if (hold_ack) state <= S_RD;
        S_RD:   state <= S_WR;
        S_WR: begin
          addr_q[cur] <= addr_q[cur] + {{(AW-1){1'b0}}, 1'b1};
          cnt_q[cur]  <= cnt_q[cur] - {{(CW-1){1'b0}}, 1'b1};
          state       <= last ? S_FIN : S_RD;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assert_dack_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dack));
  assert_dack_needs_bus_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (|dack) |-> hold_req);
  assert_no_dack_before_grant_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_req && !(|dack) && !hold_ack) |=> !(|dack));
  assert_strobe_pairs_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr) && !(io_rd && io_wr));
  assert_irq_bus_free_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (|irq) |-> (!hold_req && $onehot(irq)));
  assert_addr_steady_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_RD) |=> (addr == $past(addr)));
  assert_addr_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_WR && !last) |=> (addr == $past(addr) + {{(AW-1){1'b0}}, 1'b1}));
endmodule

// File: tb/tb_flyby_dma.sv
module tb_flyby_dma;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        cfg_we = 0;
  logic [1:0]  cfg_ch = 0, cfg_sel = 0;
  logic [15:0] cfg_wdata = 0;
  logic [3:0]  dreq = 0;
  logic [3:0]  dack, irq;
  logic        hold_req, hold_ack = 0;
  logic [15:0] addr;
  logic        mem_rd, mem_wr, io_rd, io_wr;
  int checks = 0, failures = 0;

  always #10 clk = ~clk;

  flyby_dma dut (.clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_ch(cfg_ch),
    .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .dreq(dreq), .dack(dack),
    .hold_req(hold_req), .hold_ack(hold_ack), .addr(addr), .mem_rd(mem_rd),
    .mem_wr(mem_wr), .io_rd(io_rd), .io_wr(io_wr), .irq(irq));

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] ch, input logic [1:0] sel, input logic [15:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_ch = ch; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic run_xfer(input int ch, input bit dir, input logic [15:0] a, input int n, input bit poke);
    logic [3:0] oh;
    logic [3:0] strb_rd, strb_wr;
    oh = 4'b1 << ch;
    wr(ch[1:0], 2'd0, a);
    wr(ch[1:0], 2'd2, {15'd0, dir});
    wr(ch[1:0], 2'd1, n[15:0]);
    dreq = oh;
    @(negedge clk);
    check(hold_req === 1'b1, "R3 hold_req after dreq", {31'd0, hold_req}, 1);
    check(dack === 4'd0, "R4 no dack before grant", {28'd0, dack}, 0);
    if (poke) begin
      cfg_we = 1; cfg_ch = ch[1:0]; cfg_sel = 2'd0; cfg_wdata = 16'h1234;
    end
    @(negedge clk);
    cfg_we = 0;
    check(dack === 4'd0, "R4 dack held off", {28'd0, dack}, 0);
    hold_ack = 1;
    // {mem_rd, mem_wr, io_rd, io_wr}
    strb_rd = dir ? 4'b0010 : 4'b1000;
    strb_wr = dir ? 4'b0110 : 4'b1001;
    for (int i = 0; i < n; i++) begin
      logic [15:0] ea;
      ea = a + 16'(i);
      @(negedge clk);
      if (i == 0) dreq = 0;
      check(dack === oh, "R4 dack of served channel", {28'd0, dack}, {28'd0, oh});
      check(addr === ea, poke ? "R2 ignored write, R8 addr" : "R8 addr", {16'd0, addr}, {16'd0, ea});
      check({mem_rd, mem_wr, io_rd, io_wr} === strb_rd, dir ? "R7 read phase" : "R6 read phase",
            {28'd0, mem_rd, mem_wr, io_rd, io_wr}, {28'd0, strb_rd});
      @(negedge clk);
      check(addr === ea, "R6 addr steady", {16'd0, addr}, {16'd0, ea});
      check({mem_rd, mem_wr, io_rd, io_wr} === strb_wr, dir ? "R7 write phase" : "R6 write phase",
            {28'd0, mem_rd, mem_wr, io_rd, io_wr}, {28'd0, strb_wr});
    end
    @(negedge clk);
    check(hold_req === 1'b0 && irq === oh, "R9 completion", {27'd0, hold_req, irq}, {28'd0, oh});
    hold_ack = 0;
    @(negedge clk);
    check(irq === 4'd0, "R9 irq one cycle", {28'd0, irq}, 0);
    dreq = oh;
    @(negedge clk);
    @(negedge clk);
    check(hold_req === 1'b0, "R9 disarmed, R3 unarmed dreq ignored", {31'd0, hold_req}, 0);
    dreq = 0;
    @(negedge clk);
  endtask

  initial begin
    #(20 * 200000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [3:0] first;
    int waits;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(hold_req === 0 && dack === 0 && irq === 0 && addr === 0 &&
          {mem_rd, mem_wr, io_rd, io_wr} === 0, "R1 reset outputs",
          {hold_req, dack, irq, addr, mem_rd, mem_wr, io_rd, io_wr}, 0);
    dreq = 4'hF;
    @(negedge clk);
    @(negedge clk);
    check(hold_req === 0, "R1 unarmed after reset", {31'd0, hold_req}, 0);
    dreq = 0;

    for (int ch = 0; ch < 4; ch++)
      for (int d = 0; d < 2; d++)
        for (int n = 1; n <= 3; n++)
          run_xfer(ch, d[0], 16'(ch * 16'h1000 + n * 3 + d * 7), n, (n == 2));
    run_xfer(2, 1'b0, 16'hFFFE, 4, 1'b0);
    run_xfer(1, 1'b1, 16'hFFFF, 2, 1'b1);

    // R5: simultaneous requests on channels 1 and 3
    wr(2'd3, 2'd2, 16'd0); wr(2'd3, 2'd0, 16'h0300); wr(2'd3, 2'd1, 16'd1);
    wr(2'd1, 2'd2, 16'd0); wr(2'd1, 2'd0, 16'h0100); wr(2'd1, 2'd1, 16'd1);
    hold_ack = 1;
    dreq = 4'b1010;
    waits = 0;
    first = 0;
    while (first == 0 && waits < 10) begin
      @(negedge clk);
      first = dack;
      waits++;
    end
    check(first === 4'b0010, "R5 lowest channel first", {28'd0, first}, 32'h2);
    check(addr === 16'h0100, "R5 served address", {16'd0, addr}, 32'h0100);
    dreq = 4'b1000;
    waits = 0;
    first = 0;
    while (first != 4'b1000 && waits < 10) begin
      @(negedge clk);
      first = dack;
      check($countones(dack) <= 1, "R5 single dack", {28'd0, dack}, 0);
      waits++;
    end
    check(first === 4'b1000, "R5 next channel served", {28'd0, first}, 32'h8);
    dreq = 0;
    repeat (4) @(negedge clk);
    hold_ack = 0;
    check(hold_req === 0 && dack === 0, "R9 idle after both", {27'd0, hold_req, dack}, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule